// File: doc/BRIEF.md
# Input Capture Unit with Event Prescaler

This unit records the value of a free-running timer at the moment a chosen event appears on an asynchronous input pin. The timer lives outside the unit and arrives as a bus; on each qualifying event the whole timer word is copied into a capture register, presented as an upper half and a lower half. A sticky flag marks that a capture has happened. Software clears it with a one-cycle pulse, and it drives an interrupt output gated by an enable bit.

A four-bit mode word, loaded through a write strobe together with the interrupt enable, selects the event. The choices are each falling edge, each rising edge, each fourth rising edge or each sixteenth rising edge. Any other code turns capture off. The pin passes through a two-stage synchronizer. A level-tracking state machine then turns it into registered rise and fall pulses. An event counter shared by all ratios decides which pulses produce a capture. The counter is cleared only while capture is off. A direct switch from one capture ratio to another therefore keeps the count already gathered, and the first capture after the switch can come early. Writing the off code first, then the new mode, starts the count from zero.

The edge tracker has two states, `LVL_LOW` and `LVL_HIGH`. `LVL_LOW` moves to `LVL_HIGH` when the synchronized pin reads 1 and emits a rise pulse. `LVL_HIGH` moves to `LVL_LOW` when it reads 0 and emits a fall pulse. The control machine has two states, `CTL_OFF` and `CTL_ARMED`. A write of a capture code moves either state to `CTL_ARMED`. A write of any other code moves either state to `CTL_OFF`. Without a write, both states hold.

Top module: `icap_unit`

## Requirements
- R1: When `cfg_we` is high, `cfg_mode` and `cfg_irq_en` are loaded. Code 4'b0100 captures on every falling edge, 4'b0101 on every rising edge, 4'b0110 on every 4th rising edge and 4'b0111 on every 16th rising edge. Every other code, including 4'b0000, disables capture, and pin edges then cause no capture.
- R2: A capture copies `timer_val` into the capture register, with bits 15:8 on `cap_hi` and bits 7:0 on `cap_lo`. After a pin change that causes a capture, the register and flag update at the 4th rising clock edge and are unchanged after the 3rd. The value stored is the one `timer_val` held just before that 4th edge.
- R3: Without a capture, `cap_hi`/`cap_lo` keep their value whatever `timer_val` does. A new capture overwrites an unread old value.
- R4: Every capture sets `cap_flag`. The flag stays set until `flag_clr` is pulsed, which clears it one cycle later.
- R5: When `flag_clr` and a capture occur in the same cycle, `cap_flag` ends up set.
- R6: `irq` is high exactly when `cap_flag` and the stored interrupt enable are both high. The flag is set by a capture even when the enable is 0.
- R7: While capture is off, the event counter is held at zero. After an off write followed by a write of 4'b0111, the 16th rising edge captures and the first 15 do not.
- R8: A direct write from one capture code to another keeps the event count. A capture fires on the first qualifying edge that finds the count at or above the new terminal value (0, 3 or 15). Five rising edges at ÷16 followed by a switch to ÷4 capture on the next rising edge. Two rising edges at ÷4 followed by a switch to ÷16 capture on the 14th rising edge after the switch.
- R9: After reset, the capture register reads 0, `cap_flag` and `irq` are 0, and capture is off.
- R10: An edge of the polarity the mode does not select is ignored. In rising mode a falling edge leaves `cap_flag` clear, and in falling mode a rising edge does too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous capture pin |
| timer_val | input | 16 | Free-running timer value |
| cfg_we | input | 1 | Load strobe for mode and interrupt enable |
| cfg_mode | input | 4 | Mode code |
| cfg_irq_en | input | 1 | Interrupt enable value to load |
| flag_clr | input | 1 | One-cycle capture flag clear |
| cap_hi | output | 8 | Captured timer, upper half |
| cap_lo | output | 8 | Captured timer, lower half |
| cap_flag | output | 1 | Sticky capture flag |
| irq | output | 1 | Flag gated by interrupt enable |

## Verification
The assertions assume that the synchronized pin changes no more than once every two clocks, so that a rise and a fall pulse never coincide. They also assume that a mode write never lands in the same cycle as a qualifying edge. The bench satisfies both by holding each pin level for six clocks and by issuing mode writes only after the edge pipeline has settled. It also keeps `timer_val` constant around each expected capture, so the stored value is known whatever the capture cycle.

// File: rtl/icap_pkg.sv
package icap_pkg;

    // Selected event source, decoded from the low mode bits
    typedef enum logic [1:0] {
        SEL_FALL  = 2'b00,
        SEL_RISE  = 2'b01,
        SEL_DIV4  = 2'b10,
        SEL_DIV16 = 2'b11
    } icap_sel_e;

    // Control machine: capture disabled or armed
    typedef enum logic {
        CTL_OFF   = 1'b0,
        CTL_ARMED = 1'b1
    } icap_ctl_e;

    // Edge tracker: last synchronized pin level
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } icap_lvl_e;

    localparam int MODE_W = 4;

    // Capture codes form the group 01xx
    function automatic logic mode_is_capture(input logic [MODE_W-1:0] m);
        return (m[3:2] == 2'b01);
    endfunction

    function automatic icap_sel_e mode_to_sel(input logic [MODE_W-1:0] m);
        icap_sel_e s;
        unique case (m[1:0])
            2'b00:   s = SEL_FALL;
            2'b01:   s = SEL_RISE;
            2'b10:   s = SEL_DIV4;
            default: s = SEL_DIV16;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/icap_edge.sv
module icap_edge
    import icap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise_q,
    output logic fall_q
);

    logic [SYNC_STAGES-1:0] sync_chain;
    logic                   pin_s;
    icap_lvl_e              lvl_q, lvl_d;

    // Synchronizer chain, one flop per stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_chain[0] <= 1'b0;
        else        sync_chain[0] <= pin_in;
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_chain[g] <= 1'b0;
            else        sync_chain[g] <= sync_chain[g-1];
        end
    end

    assign pin_s = sync_chain[SYNC_STAGES-1];

    // Next-state logic of the level tracker
    always_comb begin
        lvl_d = lvl_q;
        unique case (lvl_q)
            LVL_LOW:  if (pin_s)  lvl_d = LVL_HIGH;
            LVL_HIGH: if (!pin_s) lvl_d = LVL_LOW;
            default:  lvl_d = LVL_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_LOW;
        else        lvl_q <= lvl_d;
    end

    // Registered edge pulses, one per transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= (lvl_q == LVL_LOW)  && (lvl_d == LVL_HIGH);
            fall_q <= (lvl_q == LVL_HIGH) && (lvl_d == LVL_LOW);
        end
    end

endmodule

// File: rtl/icap_prescale.sv
module icap_prescale
    import icap_pkg::*;
#(
    parameter int PS_W    = 4,
    parameter int DIV_MID = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            armed,
    input  icap_sel_e       sel,
    input  logic            rise_q,
    input  logic            fall_q,
    output logic            fire,
    output logic [PS_W-1:0] cnt
);

    localparam logic [PS_W-1:0] TERM_ONE = '0;
    localparam logic [PS_W-1:0] TERM_MID = PS_W'(DIV_MID - 1);
    localparam logic [PS_W-1:0] TERM_TOP = '1;

    logic            qual;
    logic [PS_W-1:0] term;
    logic            at_term;

    always_comb begin
        unique case (sel)
            SEL_FALL:  term = TERM_ONE;
            SEL_RISE:  term = TERM_ONE;
            SEL_DIV4:  term = TERM_MID;
            default:   term = TERM_TOP;
        endcase
    end

    // Qualifying edge for the selected polarity
    assign qual    = armed && ((sel == SEL_FALL) ? fall_q : rise_q);
    // A count left above a smaller new terminal fires at once
    assign at_term = (cnt >= term);
    assign fire    = qual && at_term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!armed)  cnt <= '0;
        else if (qual)    cnt <= at_term ? '0 : cnt + PS_W'(1);
    end

endmodule

// File: rtl/icap_ctrl.sv
module icap_ctrl
    import icap_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_irq_en,
    input  logic              flag_clr,
    input  logic              fire,
    input  logic [TMR_W-1:0]  timer_val,
    output logic              armed,
    output icap_sel_e         sel,
    output logic [TMR_W-1:0]  cap_q,
    output logic              flag,
    output logic              irq
);

    icap_ctl_e state_q, state_d;
    logic      irq_en_q;

    // Next-state logic of the control machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_OFF: begin
                if (cfg_we && mode_is_capture(cfg_mode)) state_d = CTL_ARMED;
            end
            CTL_ARMED: begin
                if (cfg_we && !mode_is_capture(cfg_mode)) state_d = CTL_OFF;
            end
            default: state_d = CTL_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_OFF;
        else        state_q <= state_d;
    end

    // Output registers: selection, enable, capture word, flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel      <= SEL_FALL;
            irq_en_q <= 1'b0;
            cap_q    <= '0;
            flag     <= 1'b0;
        end else begin
            if (cfg_we) begin
                sel      <= mode_to_sel(cfg_mode);
                irq_en_q <= cfg_irq_en;
            end
            if (fire) cap_q <= timer_val;
            if (fire)          flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    assign armed = (state_q == CTL_ARMED);
    assign irq   = flag && irq_en_q;

endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int PS_W        = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_MID     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_in,
    input  logic [TMR_W-1:0]   timer_val,
    input  logic               cfg_we,
    input  logic [3:0]         cfg_mode,
    input  logic               cfg_irq_en,
    input  logic               flag_clr,
    output logic [TMR_W/2-1:0] cap_hi,
    output logic [TMR_W/2-1:0] cap_lo,
    output logic               cap_flag,
    output logic               irq
);

    localparam int HALF_W = TMR_W / 2;

    logic             rise_q, fall_q;
    logic             armed, cap_fire;
    icap_sel_e        sel;
    logic [PS_W-1:0]  ps_cnt;
    logic [TMR_W-1:0] cap_q;

    icap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .rise_q (rise_q),
        .fall_q (fall_q)
    );

    icap_prescale #(.PS_W(PS_W), .DIV_MID(DIV_MID)) u_ps (
        .clk    (clk),
        .rst_n  (rst_n),
        .armed  (armed),
        .sel    (sel),
        .rise_q (rise_q),
        .fall_q (fall_q),
        .fire   (cap_fire),
        .cnt    (ps_cnt)
    );

    icap_ctrl #(.TMR_W(TMR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_mode   (cfg_mode),
        .cfg_irq_en (cfg_irq_en),
        .flag_clr   (flag_clr),
        .fire       (cap_fire),
        .timer_val  (timer_val),
        .armed      (armed),
        .sel        (sel),
        .cap_q      (cap_q),
        .flag       (cap_flag),
        .irq        (irq)
    );

    assign cap_hi = cap_q[TMR_W-1:HALF_W];
    assign cap_lo = cap_q[HALF_W-1:0];

endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
    parameter int TMR_W = 16,
    parameter int PS_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [TMR_W-1:0]   timer_val,
    input logic               flag_clr,
    input logic               fire,
    input logic               rise_q,
    input logic               fall_q,
    input logic               armed,
    input logic [PS_W-1:0]    ps_cnt,
    input logic [TMR_W/2-1:0] cap_hi,
    input logic [TMR_W/2-1:0] cap_lo,
    input logic               cap_flag,
    input logic               irq
);

    p_fire_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> armed && (rise_q || fall_q));

    p_capture_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ({cap_hi, cap_lo} == $past(timer_val)));

    p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable({cap_hi, cap_lo}));

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cap_flag);

    p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cap_flag);

    p_off_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (ps_cnt == '0));

    p_one_polarity_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_q && fall_q));

endmodule

bind icap_unit icap_unit_chk #(.TMR_W(TMR_W), .PS_W(PS_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_val (timer_val),
    .flag_clr  (flag_clr),
    .fire      (cap_fire),
    .rise_q    (rise_q),
    .fall_q    (fall_q),
    .armed     (armed),
    .ps_cnt    (ps_cnt),
    .cap_hi    (cap_hi),
    .cap_lo    (cap_lo),
    .cap_flag  (cap_flag),
    .irq       (irq)
);

// File: tb/test_icap_unit.sv
`timescale 1ns/1ps
module test_icap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [15:0] timer_val = 16'h0000;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_mode = 4'b0000;
    logic        cfg_irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic [7:0]  cap_hi, cap_lo;
    logic        cap_flag, irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    icap_unit i_icap_unit (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .timer_val(timer_val),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_irq_en(cfg_irq_en),
        .flag_clr(flag_clr), .cap_hi(cap_hi), .cap_lo(cap_lo),
        .cap_flag(cap_flag), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [3:0] m, input logic en);
        cfg_mode = m; cfg_irq_en = en; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
        step(1);
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        pin_in = v;
        step(6);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            set_pin(1'b1);
            set_pin(1'b0);
        end
    endtask

    task automatic t_reset();
        chk("R9", "cap word", {cap_hi, cap_lo}, 0);
        chk("R9", "flag", cap_flag, 0);
        chk("R9", "irq", irq, 0);
        timer_val = 16'h1234;
        pulses(1);
        chk("R9", "no capture while off", cap_flag, 0);
        wr_mode(4'b1101, 1'b0);
        pulses(1);
        chk("R1", "undefined code disables", cap_flag, 0);
    endtask

    task automatic t_latency();
        wr_mode(4'b0101, 1'b1);
        timer_val = 16'hA55A;
        pin_in = 1'b1;
        step(3);
        chk("R2", "flag before 4th edge", cap_flag, 0);
        step(1);
        chk("R2", "flag at 4th edge", cap_flag, 1);
        chk("R2", "upper half", cap_hi, 8'hA5);
        chk("R2", "lower half", cap_lo, 8'h5A);
        step(4);
        set_pin(1'b0);
        clr_flag();
    endtask

    task automatic t_overwrite();
        timer_val = 16'h1111;
        pulses(1);
        timer_val = 16'h2222;
        pulses(1);
        chk("R3", "new capture overwrites", {cap_hi, cap_lo}, 16'h2222);
        timer_val = 16'h7777;
        step(10);
        chk("R3", "holds without event", {cap_hi, cap_lo}, 16'h2222);
    endtask

    task automatic t_sticky();
        step(20);
        chk("R4", "flag stays set", cap_flag, 1);
        clr_flag();
        chk("R4", "flag cleared", cap_flag, 0);
    endtask

    task automatic t_set_wins();
        timer_val = 16'h3C3C;
        pin_in = 1'b1;
        step(3);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        chk("R5", "set beats clear", cap_flag, 1);
        step(4);
        set_pin(1'b0);
        clr_flag();
    endtask

    task automatic t_irq_gate();
        wr_mode(4'b0101, 1'b0);
        pulses(1);
        chk("R6", "flag with enable off", cap_flag, 1);
        chk("R6", "irq masked", irq, 0);
        wr_mode(4'b0101, 1'b1);
        chk("R6", "irq with enable on", irq, 1);
        clr_flag();
        chk("R6", "irq drops with flag", irq, 0);
    endtask

    task automatic t_falling();
        wr_mode(4'b0100, 1'b0);
        timer_val = 16'h0F0F;
        set_pin(1'b1);
        chk("R10", "rising ignored in falling mode", cap_flag, 0);
        set_pin(1'b0);
        chk("R1", "falling edge captures", cap_flag, 1);
        chk("R1", "falling capture value", {cap_hi, cap_lo}, 16'h0F0F);
        clr_flag();
        wr_mode(4'b0101, 1'b0);
        set_pin(1'b1);
        clr_flag();
        set_pin(1'b0);
        chk("R10", "falling ignored in rising mode", cap_flag, 0);
    endtask

    task automatic t_div4();
        wr_mode(4'b0000, 1'b0);
        wr_mode(4'b0110, 1'b0);
        pulses(3);
        chk("R1", "div4 silent after 3 edges", cap_flag, 0);
        pulses(1);
        chk("R1", "div4 fires on 4th", cap_flag, 1);
        clr_flag();
    endtask

    task automatic t_off_clears();
        pulses(2);
        wr_mode(4'b0000, 1'b0);
        wr_mode(4'b0111, 1'b0);
        pulses(15);
        chk("R7", "div16 silent after 15", cap_flag, 0);
        pulses(1);
        chk("R7", "div16 fires on 16th", cap_flag, 1);
        clr_flag();
    endtask

    task automatic t_switch();
        pulses(5);
        chk("R8", "no capture at 5 of 16", cap_flag, 0);
        wr_mode(4'b0110, 1'b0);
        pulses(1);
        chk("R8", "early capture after switch to div4", cap_flag, 1);
        clr_flag();
        pulses(2);
        wr_mode(4'b0111, 1'b0);
        pulses(13);
        chk("R8", "silent after 13 at div16", cap_flag, 0);
        pulses(1);
        chk("R8", "fires on 14th after switch", cap_flag, 1);
        clr_flag();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_latency();
        t_overwrite();
        t_sticky();
        t_set_wins();
        t_irq_gate();
        t_falling();
        t_div4();
        t_off_clears();
        t_switch();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule